// File: doc/BRIEF.md
# Secure Test Sequence Controller

This block is a finite-state sequencer that runs the complete secure test flow of a cryptographic SoC. After a start request it first asks the block-cipher engine to authenticate the external tester. If that attempt reports failure, the controller tries again with the hash engine in keyed mode, which uses the same shared key. If the second attempt also fails, the run stops, an authentication failure is flagged and the scan wrapper stays locked.

Once either attempt succeeds, the scan wrapper of the public-key core is unlocked and a flag records which primitive did the authentication. The controller then works through a fixed sequence of phases: the scan test of the public-key core, the multiplier-based self-test of the cipher core, the same self-test of the hash core, and finally the tests of the non-cryptographic cores. Each phase receives a one-cycle start strobe and answers with a done pulse that carries a pass/fail bit. The result of each phase is latched per phase. While a run is in progress the controller holds the grant of the shared on-chip data bus. A global done output and an overall verdict close the run.

Top module: `sec_test_seq`

## Requirements
- R1: After reset every output is 0. A `go_i` high at a clock edge while the block is idle or finished starts a run. The start strobe of the cipher authentication (`phase_start_o` bit 0) follows in the next cycle.
- R2: If cipher authentication reports fail, the next phase started is keyed-hash authentication (bit 1). If cipher authentication passes, keyed-hash authentication is never started.
- R3: If keyed-hash authentication also fails, the run ends with `auth_fail_o`=1 and `done_o`=1. The wrapper stays locked and no phase with bit index 2 or higher is started.
- R4: After a successful authentication `wrapper_unlock_o` is 1 before the scan phase starts. The phases then start in ascending bit order: scan of the public-key core (bit 2), cipher self-test (bit 3), hash self-test (bit 4), other cores (bit 5). Each start strobe lasts one cycle, and at most one strobe is high at a time.
- R5: A test phase that reports fail does not stop the sequence: every later test phase still runs.
- R6: `auth_hash_used_o` is 1 after authentication by the keyed hash and 0 after authentication by the cipher.
- R7: `status_o` bit i holds the pass bit reported by phase i in the current run. Bits of phases that did not run are 0. All status bits and flags are cleared when a new run starts.
- R8: `pass_o` is 1 only when `done_o` is 1, authentication succeeded, and all four test phases (bits 2 to 5) passed.
- R9: `bus_grant_o` is 1 while a run is in progress and 0 when idle or finished. It is never high together with `done_o`.
- R10: `go_i` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Request to start a test run |
| phase_done_i | input | 1 | Done pulse from the engine of the active phase |
| phase_pass_i | input | 1 | Pass bit, valid with phase_done_i |
| phase_start_o | output | 6 | One-cycle start strobe per phase (bit index = phase) |
| wrapper_unlock_o | output | 1 | Unlocks the scan wrapper of the public-key core |
| auth_hash_used_o | output | 1 | Authentication was done by the keyed hash |
| auth_fail_o | output | 1 | Both authentication attempts failed |
| bus_grant_o | output | 1 | Controller owns the shared data bus |
| status_o | output | 6 | Latched pass bit per phase |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Overall verdict |

## Verification
The hardest situations to reach from the ports are the two-step authentication paths: the fallback to the keyed hash after a cipher failure, and the abort when both attempts fail. Both depend on the pass bit returned in one particular phase. The bench models each engine with a stub that returns a per-phase pass pattern taken from a table row, after a latency that also varies by row. This makes the fallback, the abort and failing test phases occur in separate runs. A monitor records the order of the start strobes and the lock state at each strobe. In a directed run, `go_i` is pulsed in the middle of a run to show that it has no effect.

// File: rtl/sts_pkg.sv
package sts_pkg;
  localparam int unsigned NUM_PHASES = 6;
  localparam int unsigned PH_W       = $clog2(NUM_PHASES);
  localparam int unsigned FIRST_TEST = 2;

  // order of the enum is the execution order
  typedef enum logic [PH_W-1:0] {
    PH_AUTH_CIPHER = 0,
    PH_AUTH_HASH   = 1,
    PH_SCAN_PK     = 2,
    PH_BIST_CIPHER = 3,
    PH_BIST_HASH   = 4,
    PH_MISC        = 5
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_DONE
  } state_e;
endpackage

// File: rtl/sts_seq_fsm.sv
module sts_seq_fsm
  import sts_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  go_i,
  input  logic                  done_i,
  input  logic                  pass_i,
  output logic [NUM_PHASES-1:0] start_o,
  output logic                  capture_o,
  output logic                  clear_o,
  output phase_e                phase_o,
  output logic                  busy_o,
  output logic                  finished_o
);
  state_e st_q, st_n;
  phase_e ph_q, ph_n;

  assign clear_o    = ((st_q == ST_IDLE) || (st_q == ST_DONE)) && go_i;
  assign capture_o  = (st_q == ST_WAIT) && done_i;
  assign phase_o    = ph_q;
  assign busy_o     = (st_q == ST_LAUNCH) || (st_q == ST_WAIT);
  assign finished_o = (st_q == ST_DONE);

  always_comb begin
    st_n = st_q;
    ph_n = ph_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: if (go_i) begin
        st_n = ST_LAUNCH;
        ph_n = PH_AUTH_CIPHER;
      end
      ST_LAUNCH: st_n = ST_WAIT;
      ST_WAIT: if (done_i) begin
        st_n = ST_LAUNCH;
        unique case (ph_q)
          PH_AUTH_CIPHER: ph_n = pass_i ? PH_SCAN_PK : PH_AUTH_HASH;
          PH_AUTH_HASH: begin
            if (pass_i) ph_n = PH_SCAN_PK;
            else        st_n = ST_DONE;  // abort, wrapper stays locked
          end
          PH_MISC: st_n = ST_DONE;
          default: ph_n = phase_e'(ph_q + PH_W'(1));
        endcase
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ph_q <= PH_AUTH_CIPHER;
    end else begin
      st_q <= st_n;
      ph_q <= ph_n;
    end
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_start
    assign start_o[g] = (st_q == ST_LAUNCH) && (ph_q == phase_e'(PH_W'(g)));
  end

  p_one_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));
  p_start_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |=> (start_o == '0));
  p_busy_ignores_go_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !(capture_o && ph_q == PH_MISC) && !(capture_o && ph_q == PH_AUTH_HASH && !pass_i))
      |=> busy_o);
endmodule

// File: rtl/sts_result.sv
module sts_result
  import sts_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  capture_i,
  input  phase_e                phase_i,
  input  logic                  pass_i,
  input  logic                  finished_i,
  output logic [NUM_PHASES-1:0] status_o,
  output logic                  hash_used_o,
  output logic                  unlock_o,
  output logic                  auth_fail_o,
  output logic                  pass_o
);
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_status
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                              status_o[g] <= 1'b0;
      else if (clear_i)                                         status_o[g] <= 1'b0;
      else if (capture_i && phase_i == phase_e'(PH_W'(g)))      status_o[g] <= pass_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hash_used_o <= 1'b0;
      unlock_o    <= 1'b0;
      auth_fail_o <= 1'b0;
    end else if (clear_i) begin
      hash_used_o <= 1'b0;
      unlock_o    <= 1'b0;
      auth_fail_o <= 1'b0;
    end else if (capture_i) begin
      if (phase_i == PH_AUTH_CIPHER && pass_i) begin
        unlock_o    <= 1'b1;
        hash_used_o <= 1'b0;
      end
      if (phase_i == PH_AUTH_HASH) begin
        if (pass_i) begin
          unlock_o    <= 1'b1;
          hash_used_o <= 1'b1;
        end else begin
          auth_fail_o <= 1'b1;
        end
      end
    end
  end

  assign pass_o = finished_i && !auth_fail_o && (&status_o[NUM_PHASES-1:FIRST_TEST]);

  p_abort_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auth_fail_o |-> !unlock_o);
  p_flag_needs_unlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_used_o |-> unlock_o);
  p_status_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!capture_i && !clear_i) |=> $stable(status_o));
endmodule

// File: rtl/sec_test_seq.sv
module sec_test_seq
  import sts_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  go_i,
  input  logic                  phase_done_i,
  input  logic                  phase_pass_i,
  output logic [NUM_PHASES-1:0] phase_start_o,
  output logic                  wrapper_unlock_o,
  output logic                  auth_hash_used_o,
  output logic                  auth_fail_o,
  output logic                  bus_grant_o,
  output logic [NUM_PHASES-1:0] status_o,
  output logic                  done_o,
  output logic                  pass_o
);
  logic   capture, clear, finished;
  phase_e phase;

  sts_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go_i),
    .done_i     (phase_done_i),
    .pass_i     (phase_pass_i),
    .start_o    (phase_start_o),
    .capture_o  (capture),
    .clear_o    (clear),
    .phase_o    (phase),
    .busy_o     (bus_grant_o),
    .finished_o (finished)
  );

  sts_result u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear),
    .capture_i   (capture),
    .phase_i     (phase),
    .pass_i      (phase_pass_i),
    .finished_i  (finished),
    .status_o    (status_o),
    .hash_used_o (auth_hash_used_o),
    .unlock_o    (wrapper_unlock_o),
    .auth_fail_o (auth_fail_o),
    .pass_o      (pass_o)
  );

  assign done_o = finished;

  p_scan_unlocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_start_o[FIRST_TEST+:NUM_PHASES-FIRST_TEST] != '0) |-> wrapper_unlock_o);
  p_grant_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_grant_o && done_o));
  p_pass_needs_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (done_o && !auth_fail_o));
endmodule

// File: tb/sec_test_seq_tb_top.sv
module sec_test_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 6;
  localparam int NROWS = 5;
  // {pass pattern, started mask, status, hash_used, auth_fail, pass, unlock, latency}
  localparam logic [25:0] VEC [NROWS] = '{
    {6'b111101, 6'b111101, 6'b111101, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1},
    {6'b111110, 6'b111111, 6'b111110, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2},
    {6'b111100, 6'b000011, 6'b000000, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3},
    {6'b101011, 6'b111101, 6'b101001, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},
    {6'b011110, 6'b111111, 6'b011110, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic done_s, pass_s;
  logic [NPH-1:0] start, status;
  logic unlock, hash_used, afail, grant, done, pass;

  int checks = 0, fails = 0, cycles = 0;
  logic [NPH-1:0] cur_pat = '0;
  logic [3:0] cur_lat = 4'd1;
  logic [NPH-1:0] seen = '0;
  int last_idx = -1;
  logic [3:0] cnt;
  int ph;
  bit summary_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_test_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go),
    .phase_done_i(done_s), .phase_pass_i(pass_s),
    .phase_start_o(start), .wrapper_unlock_o(unlock),
    .auth_hash_used_o(hash_used), .auth_fail_o(afail),
    .bus_grant_o(grant), .status_o(status), .done_o(done), .pass_o(pass)
  );

  function automatic int idx_of(logic [NPH-1:0] v);
    for (int i = 0; i < NPH; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // engine stub: done pulse with per-phase pass bit after cur_lat cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; done_s <= 1'b0; pass_s <= 1'b0; ph <= 0;
    end else if (start != '0) begin
      cnt <= cur_lat; done_s <= 1'b0; ph <= idx_of(start);
    end else if (cnt != '0) begin
      cnt <= cnt - 4'd1;
      done_s <= (cnt == 4'd1);
      if (cnt == 4'd1) pass_s <= cur_pat[ph];
    end else begin
      done_s <= 1'b0;
    end
  end

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n && start != '0) begin
      int i;
      i = idx_of(start);
      chk("R4 start order", 32'(i > last_idx), 32'd1);
      chk("R9 grant during run", 32'(grant), 32'd1);
      if (i >= 2) chk("R4 unlocked before test phase", 32'(unlock), 32'd1);
      else        chk("R4 locked during auth", 32'(unlock), 32'd0);
      last_idx = i;
      seen = seen | start;
    end
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic run(logic [25:0] v, bit busy_go, string tag);
    int n;
    cur_pat = v[25:20]; cur_lat = v[3:0]; seen = '0; last_idx = -1;
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      go = (busy_go && n == 6); // R10: stray request mid-run
    end
    go = 1'b0;
    chk({tag, " R1 run finished"}, 32'(done), 32'd1);
    chk({tag, " R2/R3/R5 started phases"}, 32'(seen), 32'(v[19:14]));
    chk({tag, " R7 status"}, 32'(status), 32'(v[13:8]));
    chk({tag, " R6 hash flag"}, 32'(hash_used), 32'(v[7]));
    chk({tag, " R3 auth fail"}, 32'(afail), 32'(v[6]));
    chk({tag, " R8 overall pass"}, 32'(pass), 32'(v[5]));
    chk({tag, " R3/R4 unlock"}, 32'(unlock), 32'(v[4]));
    chk({tag, " R9 grant released"}, 32'(grant), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset start", 32'(start), 32'd0);
    chk("R1 reset unlock", 32'(unlock), 32'd0);
    chk("R1 reset done", 32'(done), 32'd0);
    chk("R9 reset grant", 32'(grant), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle status", 32'(status), 32'd0);
    chk("R1 idle pass/fail", 32'({pass, afail, hash_used}), 32'd0);
    // R1: strobe one cycle after go
    @(negedge clk) go = 1'b1; cur_pat = 6'b111101; cur_lat = 4'd1;
    @(negedge clk) go = 1'b0;
    chk("R1 cipher auth strobe", 32'(start), 32'd1);
    while (!done) @(negedge clk);
    for (int r = 0; r < NROWS; r++) run(VEC[r], 1'b0, $sformatf("row%0d", r));
    run(VEC[0], 1'b1, "R10 go while busy");
    run(VEC[2], 1'b1, "R10 go during abort path");
    summary();
  end
endmodule